// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

The block gathers a bank of level-sensitive interrupt inputs, filters them through a per-source mask and picks one winner by programmable priority. It raises a single request line toward the processor. Software reads the number of the chosen source from a sorted-number register. It then writes an acknowledge bit so that the controller can choose again. The number stays latched between the choice and the acknowledge, so later changes on the inputs do not alter what software reads in that window.

Sources come in groups of 32, and the count is set by the `NUM_GRP` parameter (3 groups for 96 sources, or 4 for 128). Each group has a mask word with two aliases, a write-one-to-clear alias and a write-one-to-set alias, plus a read-only pending word. Each source has an 8-bit level register that holds its priority. A global threshold can exclude the less urgent sources.

The register bus uses a word address (byte offset divided by 4) with one-cycle read and write strobes. Read data is registered: it appears the cycle after `rd_en` and holds until the next read. A soft reset and a few plain configuration registers complete the map.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every source is masked (each mask word at byte 0x84+0x20*n reads 0xFFFFFFFF), `irq_out` is 0, the threshold reads 0xFF, every level register reads 0, and byte 0x00 reads 0x40 (major 4 in bits [7:4], minor 0 in bits [3:0]).
- R2: A mask bit of 1 blocks its source. A write to byte 0x88+0x20*n clears exactly the mask bits written as 1. A write to 0x8C+0x20*n sets exactly those bits. A write to 0x84+0x20*n loads the whole word.
- R3: The pending word at byte 0x98+0x20*n reads as group n of `irq_src` ANDed with the inverted mask, and a write to it changes nothing.
- R4: Among eligible sources, the one with the smallest priority (bits [7:2] of its level register at byte 0x100+4*i) is chosen. On equal priority, the lower source number wins.
- R5: A source whose priority is not below the threshold (bits [7:0] at byte 0x68) cannot be chosen, except when the threshold is 0xFF.
- R6: When nothing is latched and a source is eligible, `irq_out` is 1 from the next cycle. Bits [6:0] of the sorted register at byte 0x40 then give the chosen number.
- R7: While a choice is latched and not acknowledged, `irq_out` stays 1 and the sorted number does not change, even if the source drops or a more urgent one arrives.
- R8: Writing 1 to bit 0 at byte 0x48 clears the latch. `irq_out` is 0 for the next cycle, and if a source is still eligible a new choice is latched on the cycle after.
- R9: An acknowledge written while nothing is latched has no effect, and the next eligible source is taken normally.
- R10: Writing 1 to bit 1 at byte 0x10 returns masks, level registers, threshold, latch and plain registers to their reset values one cycle later. Bit 0 at byte 0x14 reads 1 once that is done.
- R11: Autoidle (bit 0 at byte 0x10), idle bits [1:0] at byte 0x50, protection bit 0 at byte 0x4C, the threshold and the level registers all read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| waddr | input | 10 | Word address of the register access |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe, one cycle |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_src | input | 32*NUM_GRP | Level interrupt inputs |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The hold, acknowledge and relatch properties assume that `irq_src` and the bus strobes are synchronous to `clk` and never change near its rising edge. The alias properties assume that one write touches one address in a cycle. The bench meets both assumptions by changing every input on the falling edge and by issuing one strobe per transaction. Soft resets are started only from idle bus cycles, so no write lands in the cycle that clears the registers.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int AW = 10;
    typedef logic [AW-1:0] waddr_t;

    localparam waddr_t W_REV  = 10'd0;
    localparam waddr_t W_CFG  = 10'd4;
    localparam waddr_t W_STAT = 10'd5;
    localparam waddr_t W_SORT = 10'd16;
    localparam waddr_t W_CTRL = 10'd18;
    localparam waddr_t W_PROT = 10'd19;
    localparam waddr_t W_IDLE = 10'd20;
    localparam waddr_t W_THR  = 10'd26;
    localparam waddr_t W_LVL0 = 10'd64;

    localparam int GRP_BASE   = 33;
    localparam int GRP_STRIDE = 8;
    localparam int OFS_CLR    = 1;
    localparam int OFS_SET    = 2;
    localparam int OFS_PEND   = 5;

    function automatic waddr_t grp_addr(input int g, input int ofs);
        return waddr_t'(GRP_BASE + GRP_STRIDE * g + ofs);
    endfunction
endpackage

// File: rtl/prio_irq_mask_bank.sv
module prio_irq_mask_bank
    import prio_irq_pkg::*;
#(
    parameter int NUM_GRP = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_all,
    input  logic                   wr_en,
    input  waddr_t                 waddr,
    input  logic [31:0]            wr_data,
    output logic [NUM_GRP*32-1:0]  mask
);
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam waddr_t A_DIR = grp_addr(g, 0);
        localparam waddr_t A_CLR = grp_addr(g, OFS_CLR);
        localparam waddr_t A_SET = grp_addr(g, OFS_SET);
        logic [31:0] m_d, m_q;

        always_comb begin
            m_d = m_q;
            if (clr_all) begin
                m_d = '1;
            end else if (wr_en) begin
                if (waddr == A_DIR)      m_d = wr_data;
                else if (waddr == A_CLR) m_d = m_q & ~wr_data;
                else if (waddr == A_SET) m_d = m_q | wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) m_q <= '1;
            else        m_q <= m_d;
        end

        assign mask[g*32 +: 32] = m_q;

        // R2
        clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !clr_all && waddr == A_CLR) |=> ((m_q & $past(wr_data)) == 32'h0));
        // R2
        set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !clr_all && waddr == A_SET) |=> ((m_q & $past(wr_data)) == $past(wr_data)));
        // R10
        srst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr_all |=> (m_q == 32'hFFFF_FFFF));
    end
endmodule

// File: rtl/prio_irq_sel.sv
module prio_irq_sel #(
    parameter int NUM_SRC = 96,
    parameter int IDW     = 7
) (
    input  logic [NUM_SRC-1:0]      pend,
    input  logic [NUM_SRC-1:0][5:0] prio,
    input  logic [7:0]              thr,
    output logic                    any,
    output logic [IDW-1:0]          win
);
    logic [5:0] best;
    logic       elig;

    always_comb begin
        any  = 1'b0;
        win  = '0;
        best = 6'h3F;
        elig = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            elig = pend[i] && ((thr == 8'hFF) || ({2'b00, prio[i]} < thr));
            if (elig && (!any || (prio[i] < best))) begin
                any  = 1'b1;
                best = prio[i];
                win  = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int         NUM_GRP   = 3,
    parameter logic [3:0] REV_MAJOR = 4'd4,
    parameter logic [3:0] REV_MINOR = 4'd0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [9:0]            waddr,
    input  logic                  wr_en,
    input  logic [31:0]           wr_data,
    input  logic                  rd_en,
    output logic [31:0]           rd_data,
    input  logic [NUM_GRP*32-1:0] irq_src,
    output logic                  irq_out
);
    localparam int     NUM_SRC   = NUM_GRP * 32;
    localparam int     IDW       = $clog2(NUM_SRC);
    localparam waddr_t W_LVL_END = W_LVL0 + waddr_t'(NUM_SRC);

    typedef struct packed {
        logic           valid;
        logic [IDW-1:0] active;
        logic [7:0]     thr;
        logic           prot;
        logic [1:0]     idle;
        logic           autoidle;
        logic           srst;
        logic [31:0]    rd;
    } st_t;

    localparam st_t ST_RST = '{valid: 1'b0, active: '0, thr: 8'hFF, prot: 1'b0,
                               idle: 2'b00, autoidle: 1'b0, srst: 1'b0, rd: 32'h0};

    st_t                      st_d, st_q;
    logic [NUM_SRC-1:0][7:0]  lvl_d, lvl_q;
    logic [NUM_SRC-1:0]       mask, pend;
    logic [NUM_SRC-1:0][5:0]  prio;
    logic                     sel_any;
    logic [IDW-1:0]           sel_win;
    logic                     ack;
    logic [31:0]              rmux;
    waddr_t                   loff;

    prio_irq_mask_bank #(.NUM_GRP(NUM_GRP)) u_mask (
        .clk(clk), .rst_n(rst_n), .clr_all(st_q.srst), .wr_en(wr_en),
        .waddr(waddr), .wr_data(wr_data), .mask(mask)
    );

    assign pend = irq_src & ~mask;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
        assign prio[i] = lvl_q[i][7:2];
    end

    prio_irq_sel #(.NUM_SRC(NUM_SRC), .IDW(IDW)) u_sel (
        .pend(pend), .prio(prio), .thr(st_q.thr), .any(sel_any), .win(sel_win)
    );

    assign ack  = wr_en && (waddr == W_CTRL) && wr_data[0];
    assign loff = waddr - W_LVL0;

    // read multiplexer
    always_comb begin
        rmux = 32'h0;
        case (waddr)
            W_REV:   rmux[7:0]     = {REV_MAJOR, REV_MINOR};
            W_CFG:   rmux[0]       = st_q.autoidle;
            W_STAT:  rmux[0]       = !st_q.srst;
            W_SORT:  rmux[IDW-1:0] = st_q.active;
            W_PROT:  rmux[0]       = st_q.prot;
            W_IDLE:  rmux[1:0]     = st_q.idle;
            W_THR:   rmux[7:0]     = st_q.thr;
            default: ;
        endcase
        for (int g = 0; g < NUM_GRP; g++) begin
            if (waddr == grp_addr(g, 0))        rmux = mask[g*32 +: 32];
            if (waddr == grp_addr(g, OFS_PEND)) rmux = pend[g*32 +: 32];
        end
        if (waddr >= W_LVL0 && waddr < W_LVL_END) rmux[7:0] = lvl_q[loff[IDW-1:0]];
    end

    // next-state computation
    always_comb begin
        st_d  = st_q;
        lvl_d = lvl_q;
        if (st_q.srst) begin
            st_d    = ST_RST;
            st_d.rd = st_q.rd;
            lvl_d   = '0;
        end else begin
            if (wr_en) begin
                case (waddr)
                    W_CFG: begin
                        st_d.autoidle = wr_data[0];
                        st_d.srst     = wr_data[1];
                    end
                    W_PROT:  st_d.prot = wr_data[0];
                    W_IDLE:  st_d.idle = wr_data[1:0];
                    W_THR:   st_d.thr  = wr_data[7:0];
                    default: begin
                        if (waddr >= W_LVL0 && waddr < W_LVL_END)
                            lvl_d[loff[IDW-1:0]] = wr_data[7:0];
                    end
                endcase
            end
            if (ack) begin
                st_d.valid = 1'b0;
            end else if (!st_q.valid && sel_any) begin
                st_d.valid  = 1'b1;
                st_d.active = sel_win;
            end
        end
        if (rd_en) st_d.rd = rmux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RST;
            lvl_q <= '0;
        end else begin
            st_q  <= st_d;
            lvl_q <= lvl_d;
        end
    end

    assign irq_out = st_q.valid;
    assign rd_data = st_q.rd;

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !ack && !st_q.srst) |=> (irq_out && $stable(st_q.active)));
    // R8
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && ack && !st_q.srst) |=> !irq_out);
    // R6
    latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.valid && sel_any && !ack && !st_q.srst) |=> (irq_out && st_q.active == $past(sel_win)));
    // R4
    win_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_any |-> pend[sel_win]);
    // R5
    thr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_any |-> (st_q.thr == 8'hFF || {2'b00, lvl_q[sel_win][7:2]} < st_q.thr));
    // R10
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.srst |=> (!irq_out && st_q.thr == 8'hFF && !st_q.srst));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
    localparam int NG = 3;
    localparam int NS = NG * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [9:0]    waddr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [31:0]   rd_data;
    logic [NS-1:0] src = '0;
    logic          irq_out;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl #(.NUM_GRP(NG)) u0 (
        .clk(clk), .rst_n(rst_n), .waddr(waddr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .irq_src(src), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int off, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; waddr = 10'(off >> 2); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int off, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; waddr = 10'(off >> 2);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic idle_out();
        @(negedge clk);
        src = '0;
        wr(32'h48, 32'h1);
        @(negedge clk);
    endtask

    function automatic int pr(input int i, input int k);
        return (i * (7 + 10 * k) + 3 * k + 5) % 64;
    endfunction

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            report();
        end
    end

    initial begin
        logic [31:0] d;
        logic [NS-1:0] pat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_out", 32'(irq_out), 0);
        rd(32'h00, d); chk("R1 revision", d, 32'h40);
        for (int g = 0; g < NG; g++) begin
            rd(32'h84 + 32 * g, d); chk("R1 mask", d, 32'hFFFF_FFFF);
        end
        rd(32'h68, d); chk("R1 threshold", d, 32'hFF);
        rd(32'h100 + 4 * 17, d); chk("R1 level", d, 0);

        // R2 aliases
        wr(32'h88 + 32, 32'h0000_0005);
        rd(32'h84 + 32, d); chk("R2 clr alias", d, 32'hFFFF_FFFA);
        wr(32'h8C + 32, 32'h0000_0001);
        rd(32'h84 + 32, d); chk("R2 set alias", d, 32'hFFFF_FFFB);
        wr(32'h84 + 64, 32'h1234_5678);
        rd(32'h84 + 64, d); chk("R2 direct", d, 32'h1234_5678);

        // R3 pending under several mask/source patterns
        wr(32'h84, 32'h0F0F_0F0F);
        wr(32'h84 + 32, 32'hFFFF_0000);
        @(negedge clk);
        src = {32'hFFFF_FFFF, 32'h00FF_FF00, 32'hAAAA_5555};
        rd(32'h98, d);      chk("R3 pend g0", d, 32'hAAAA_5555 & ~32'h0F0F_0F0F);
        rd(32'h98 + 32, d); chk("R3 pend g1", d, 32'h00FF_FF00 & ~32'hFFFF_0000);
        rd(32'h98 + 64, d); chk("R3 pend g2", d, 32'hFFFF_FFFF & ~32'h1234_5678);
        wr(32'h98, 32'h0);
        rd(32'h98, d);      chk("R3 pend write ignored", d, 32'hAAAA_5555 & ~32'h0F0F_0F0F);
        idle_out();

        // unmask all, then single-source sweep: R6
        for (int g = 0; g < NG; g++) wr(32'h88 + 32 * g, 32'hFFFF_FFFF);
        for (int i = 0; i < NS; i++) begin
            @(negedge clk);
            src = '0; src[i] = 1'b1;
            @(negedge clk);
            chk("R6 irq_out", 32'(irq_out), 1);
            rd(32'h40, d); chk("R6 sorted", d, 32'(i));
            @(negedge clk);
            src = '0;
            wr(32'h48, 32'h1);
            chk("R8 low after ack", 32'(irq_out), 0);
            @(negedge clk);
            chk("R8 stays low", 32'(irq_out), 0);
        end

        // R7 hold, R8 one-cycle drop and relatch
        @(negedge clk);
        src = '0; src[5] = 1'b1;
        @(negedge clk);
        src[5] = 1'b0; src[7] = 1'b1; src[2] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R7 irq held", 32'(irq_out), 1);
        rd(32'h40, d); chk("R7 number held", d, 5);
        wr(32'h48, 32'h1);
        chk("R8 drop", 32'(irq_out), 0);
        @(negedge clk);
        chk("R8 relatch", 32'(irq_out), 1);
        rd(32'h40, d); chk("R8 new number", d, 2);
        idle_out();

        // R9 ack with nothing latched
        wr(32'h48, 32'h1);
        chk("R9 no effect", 32'(irq_out), 0);
        @(negedge clk);
        src = '0; src[3] = 1'b1;
        @(negedge clk);
        chk("R9 normal take", 32'(irq_out), 1);
        rd(32'h40, d); chk("R9 number", d, 3);
        idle_out();

        // R4/R5 priority sweeps with arithmetic expectation
        for (int k = 0; k < 5; k++) begin
            int thr, best, win;
            bit any;
            thr = (k == 2) ? 20 : (k == 3) ? 3 : (k == 4) ? 0 : 255;
            for (int i = 0; i < NS; i++) wr(32'h100 + 4 * i, 32'(pr(i, k) << 2));
            wr(32'h68, 32'(thr));
            pat = (k == 1 || k == 3) ? {NG{32'hA5C3_3C5A}} : '1;
            any = 0; best = 99; win = 0;
            for (int i = 0; i < NS; i++)
                if (pat[i] && (thr == 255 || pr(i, k) < thr) && (!any || pr(i, k) < best)) begin
                    any = 1; best = pr(i, k); win = i;
                end
            @(negedge clk);
            src = pat;
            @(negedge clk); @(negedge clk);
            chk((k >= 2) ? "R5 threshold irq" : "R4 priority irq", 32'(irq_out), 32'(any));
            if (any) begin
                rd(32'h40, d);
                chk((k >= 2) ? "R5 threshold winner" : "R4 priority winner", d, 32'(win));
            end
            idle_out();
        end

        // R11 plain registers
        wr(32'h10, 32'h1); rd(32'h10, d); chk("R11 autoidle", d, 1);
        wr(32'h50, 32'h2); rd(32'h50, d); chk("R11 idle", d, 2);
        wr(32'h4C, 32'h1); rd(32'h4C, d); chk("R11 protection", d, 1);
        wr(32'h68, 32'h3C); rd(32'h68, d); chk("R11 threshold", d, 32'h3C);
        wr(32'h100 + 4 * 9, 32'hB7); rd(32'h100 + 4 * 9, d); chk("R11 level", d, 32'hB7);

        // R10 soft reset with a latched request
        wr(32'h68, 32'hFF);
        @(negedge clk);
        src = '0; src[1] = 1'b1;
        @(negedge clk);
        chk("R10 pre irq", 32'(irq_out), 1);
        wr(32'h10, 32'h2);
        @(negedge clk);
        chk("R10 irq cleared", 32'(irq_out), 0);
        rd(32'h14, d); chk("R10 done flag", d, 1);
        rd(32'h84, d); chk("R10 mask", d, 32'hFFFF_FFFF);
        rd(32'h100 + 4 * 9, d); chk("R10 level", d, 0);
        rd(32'h10, d); chk("R10 cfg", d, 0);
        rd(32'h50, d); chk("R10 idle", d, 0);
        chk("R10 masked source", 32'(irq_out), 0);

        finished = 1;
        report();
    end
endmodule